// File: doc/BRIEF.md
# Byte-to-Word Access Adapter

This block connects a requester that addresses memory by byte to a memory port that can only move complete 32-bit words. Each request address is split into a word address (the upper bits) and a byte lane offset (the low bits). A word-sized request goes through to the memory as a single operation. A byte read fetches the containing word and returns the selected lane. A byte write performs a read-modify-write: it fetches the word, replaces one lane with the new byte, and writes the whole word back.

The requester side uses a valid/ready request channel and a one-cycle response strobe. A request is accepted on a rising edge where both `reqValid` and `reqReady` are high. The adapter then stays busy for the whole sequence. This prevents any other access from landing between the read and the write-back of a merge. After each response the adapter spends one recovery cycle before it accepts again, so throughput is set by its cycle time rather than by its latency. The memory side is a synchronous port with an enable, a write flag and a fixed one-cycle read latency.

Top module: `byte_word_adapter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `reqReady` is 1 and both `rspValid` and `memEn` are 0.
- R2: Every memory operation for a request drives `memAddr` with the request address shifted right by 2 (byte address divided by 4, remainder dropped).
- R3: A byte read (`reqWrite`=0, `reqWord`=0) issues exactly one memory read and no write. It returns in `rspData` the byte at lane `reqAddr[1:0]`, zero-extended, with little-endian lanes: lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: A byte write (`reqWrite`=1, `reqWord`=0) issues one memory read followed by one write to the same word address. The written word equals the old word with lane `reqAddr[1:0]` replaced by `reqWdata[7:0]`. The other three lanes are unchanged, and `reqWdata[31:8]` is ignored.
- R5: A word read (`reqWrite`=0, `reqWord`=1) issues exactly one memory read and returns the full word unchanged in `rspData`. The offset bits are ignored.
- R6: A word write (`reqWrite`=1, `reqWord`=1) issues exactly one memory write of `reqWdata` and no read. The offset bits are ignored.
- R7: `rspValid` is high for exactly one cycle. Counting rising edges after the acceptance edge, it is high in cycle 2 for any read, in cycle 3 for a byte write and in cycle 1 for a word write. For writes, `rspData` then shows the word written.
- R8: `reqReady` is 0 from the acceptance edge until one recovery cycle after the response. It returns to 1 in the second cycle after the `rspValid` cycle.
- R9: `memEn` is 0 whenever `reqReady` is 1 and during the recovery cycle. `memWe` is never 1 without `memEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Adapter idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = full-word access, 0 = single byte |
| reqAddr | input | 8 | Byte address |
| reqWdata | input | 32 | Write data; only bits 7:0 are used for byte writes |
| rspValid | output | 1 | Single-cycle completion strobe |
| rspData | output | 32 | Read result, or the word written |
| memEn | output | 1 | Memory operation enable |
| memWe | output | 1 | Memory write when high, read when low |
| memAddr | output | 6 | Word address |
| memWdata | output | 32 | Word to write |
| memRdata | input | 32 | Read word, valid the cycle after a read is issued |

## Verification
Each result is due a fixed number of rising edges after the acceptance edge. A word write answers after 1 edge, either read after 2, and a byte write after 3. `reqReady` comes back two edges after the response. The bench drives on falling edges and samples each falling edge of a six-cycle window after acceptance, recording the exact cycle of the response and of the return of ready. It also counts and captures every memory read and write in that window, so latency, operation count, word address and merged data are each compared with values derived from a byte-array reference.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_RETURN,
    ST_RMW_READ,
    ST_RMW_MERGE,
    ST_WR_ISSUE,
    ST_RECOVER
  } bwa_state_e;

  typedef struct packed {
    logic capture;     // latch the accepted request
    logic loadMerge;   // replace one lane of the fetched word
    logic rspFromMem;  // response carries memory read data
  } bwa_strobe_t;

endpackage

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqWord,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memEn,
  output logic        memWe,
  output bwa_strobe_t strobe
);

  bwa_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (!reqWrite)    stateNext = ST_RD_ISSUE;
          else if (reqWord) stateNext = ST_WR_ISSUE;
          else              stateNext = ST_RMW_READ;
        end
      end
      ST_RD_ISSUE: begin
        memEn     = 1'b1;
        stateNext = ST_RD_RETURN;
      end
      ST_RD_RETURN: begin
        rspValid          = 1'b1;
        strobe.rspFromMem = 1'b1;
        stateNext         = ST_RECOVER;
      end
      ST_RMW_READ: begin
        memEn     = 1'b1;
        stateNext = ST_RMW_MERGE;
      end
      ST_RMW_MERGE: begin
        strobe.loadMerge = 1'b1;
        stateNext        = ST_WR_ISSUE;
      end
      ST_WR_ISSUE: begin
        memEn     = 1'b1;
        memWe     = 1'b1;
        rspValid  = 1'b1;
        stateNext = ST_RECOVER;
      end
      ST_RECOVER: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bwa_datapath.sv
module bwa_datapath
  import bwa_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int WADDR_W   = ADDR_W - OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  bwa_strobe_t        strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWord,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [WADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWdata,
  output logic [WORD_W-1:0]  rspData
);

  logic [WADDR_W-1:0] wordAddrReg;
  logic [OFF_W-1:0]   laneReg;
  logic               wordReg;
  logic [BYTE_W-1:0]  byteReg;
  logic [WORD_W-1:0]  dataReg;
  logic [WORD_W-1:0]  merged;
  logic [BYTE_W-1:0]  pickedByte;

  // Replace exactly one lane of the fetched word.
  for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_merge
    assign merged[lane*BYTE_W +: BYTE_W] =
      (laneReg == OFF_W'(lane)) ? byteReg : memRdata[lane*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pickedByte = '0;
    for (int lane = 0; lane < WORD_BYTES; lane++) begin
      if (laneReg == OFF_W'(lane)) pickedByte = memRdata[lane*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddrReg <= '0;
      laneReg     <= '0;
      wordReg     <= 1'b0;
      byteReg     <= '0;
      dataReg     <= '0;
    end else if (strobe.capture) begin
      wordAddrReg <= reqAddr[ADDR_W-1:OFF_W];
      laneReg     <= reqAddr[OFF_W-1:0];
      wordReg     <= reqWord;
      byteReg     <= reqWdata[BYTE_W-1:0];
      dataReg     <= reqWdata;
    end else if (strobe.loadMerge) begin
      dataReg     <= merged;
    end
  end

  assign memAddr  = wordAddrReg;
  assign memWdata = dataReg;

  always_comb begin
    if (!strobe.rspFromMem) rspData = dataReg;
    else if (wordReg)       rspData = memRdata;
    else                    rspData = {{(WORD_W-BYTE_W){1'b0}}, pickedByte};
  end

endmodule

// File: rtl/byte_word_adapter.sv
module byte_word_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int WADDR_W   = ADDR_W - OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic               reqWord,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [WORD_W-1:0]  rspData,
  output logic               memEn,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic [WORD_W-1:0]  memRdata
);

  bwa_strobe_t strobe;

  bwa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .memEn    (memEn),
    .memWe    (memWe),
    .strobe   (strobe)
  );

  bwa_datapath #(
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWord  (reqWord),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rspData  (rspData)
  );

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int WADDR_W = 6
)(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               rspValid,
  input logic               memEn,
  input logic               memWe,
  input logic [WADDR_W-1:0] memAddr
);

  // R1: idle outputs while reset holds
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_idle: assert (reqReady && !rspValid && !memEn)
        else $error("reset state wrong");
    end
  end

  a_r9_we_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  a_r9_idle_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memEn);

  a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r8_recover_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!reqReady && !memEn));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r8_ready_after_recover: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> ##1 reqReady);

  a_r4_rmw_same_word: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && $past(memEn, 2) && !$past(memWe, 2))
      |-> (memAddr == $past(memAddr, 2)));

endmodule

bind byte_word_adapter bwa_checker #(.WADDR_W(WADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/test_byte_word_adapter.sv
`timescale 1ns/1ps
module test_byte_word_adapter;

  localparam int ADDR_W  = 8;
  localparam int WADDR_W = 6;
  localparam int NBYTES  = 1 << ADDR_W;
  localparam int NWORDS  = 1 << WADDR_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, memEn, memWe;
  logic [31:0] rspData, memWdata;
  logic [31:0] memRdata = '0;
  logic [5:0]  memAddr;

  logic [31:0] mem [NWORDS];
  logic [7:0]  refMem [NBYTES];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_word_adapter i_byte_word_adapter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Word memory with one-cycle read latency
  always @(posedge clk) begin
    if (memEn && memWe)  mem[memAddr] <= memWdata;
    if (memEn && !memWe) memRdata <= mem[memAddr];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(input int a);
    int b = a & ~3;
    return {refMem[b+3], refMem[b+2], refMem[b+1], refMem[b]};
  endfunction

  task automatic access(input bit wr, input bit wd, input logic [7:0] a,
                        input logic [31:0] d);
    int rspCyc = 0, readyCyc = 0, nRd = 0, nWr = 0;
    logic [31:0] gotRsp = '0, gotWr = '0;
    bit addrOk = 1;
    int expRsp, nRdExp, nWrExp;
    logic [31:0] expData, oldWord;
    oldWord = refWord(a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (memEn) begin
        if (memAddr != a[7:2]) addrOk = 0;
        if (memWe) begin nWr++; gotWr = memWdata; end
        else nRd++;
      end
      if (rspValid && rspCyc == 0) begin rspCyc = k; gotRsp = rspData; end
      if (reqReady && readyCyc == 0) readyCyc = k;
    end
    if (!wr)      begin expRsp = 2; nRdExp = 1; nWrExp = 0; end
    else if (wd)  begin expRsp = 1; nRdExp = 0; nWrExp = 1; end
    else          begin expRsp = 3; nRdExp = 1; nWrExp = 1; end
    check(rspCyc == expRsp, "R7 response cycle", rspCyc, expRsp);
    check(readyCyc == expRsp + 2, "R8 ready return", readyCyc, expRsp + 2);
    check(addrOk, "R2 word address", {26'd0, memAddr}, {26'd0, a[7:2]});
    if (!wr && !wd) begin
      expData = {24'd0, refMem[a]};
      check(gotRsp == expData, "R3 byte read data", gotRsp, expData);
      check(nRd == 1 && nWr == 0, "R3 one read no write", nRd*16 + nWr, 16);
    end else if (!wr) begin
      check(gotRsp == oldWord, "R5 word read data", gotRsp, oldWord);
      check(nRd == 1 && nWr == 0, "R5 one read", nRd*16 + nWr, 16);
    end else if (wd) begin
      check(gotWr == d, "R6 word write data", gotWr, d);
      check(nRd == nRdExp && nWr == nWrExp, "R6 one write no read", nRd*16 + nWr, 1);
      check(gotRsp == d, "R7 write ack data", gotRsp, d);
      for (int i = 0; i < 4; i++) refMem[(a & ~3) + i] = d[i*8 +: 8];
    end else begin
      expData = oldWord;
      expData[a[1:0]*8 +: 8] = d[7:0];
      check(gotWr == expData, "R4 merged word", gotWr, expData);
      check(nRd == nRdExp && nWr == nWrExp, "R4 read then write", nRd*16 + nWr, 17);
      refMem[a] = d[7:0];
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NWORDS; w++) begin
      mem[w] = 32'h5A3C_0000 ^ (w * 32'h0103_0507);
      for (int i = 0; i < 4; i++) refMem[w*4 + i] = mem[w][i*8 +: 8];
    end
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !memEn, "R1 reset outputs",
          {reqReady, rspValid, memEn}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !memEn, "R1 after release",
          {reqReady, rspValid, memEn}, 3'b100);
    check(!memEn && !memWe, "R9 idle memory quiet", {memEn, memWe}, 0);

    // Directed: every lane of one word
    for (int i = 0; i < 4; i++) access(0, 0, 8'h10 + i, 0);
    for (int i = 0; i < 4; i++) access(1, 0, 8'h20 + i, 32'hFFFF_FF00 | (8'hC0 + i));
    access(0, 1, 8'h22, 0);               // R5 offset ignored
    access(1, 1, 8'h33, 32'hDEAD_BEEF);   // R6 offset ignored
    for (int i = 0; i < 4; i++) access(0, 0, 8'h30 + i, 0);
    access(1, 0, 8'hFF, 32'h0000_0077);   // top lane, last word
    access(0, 1, 8'hFC, 0);
    access(1, 0, 8'h00, 32'h0000_0011);   // lane 0, first word
    access(0, 1, 8'h01, 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 3);
      logic [7:0] a = 8'($urandom_range(0, NBYTES - 1));
      access(kind[0], kind[1], a, $urandom);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule